// File: doc/BRIEF.md
# Preemptive Priority DRR Scheduler

This block arbitrates one egress port among a flat, single-stage set of flow queues. Each queue has its own programmable priority level and its own deficit round robin quantum. When packets are waiting, the block always grants a queue at the highest backlogged level. Queues that share that level take turns under deficit round robin. Each level keeps its own rotation pointer. Serving a higher level therefore leaves the position of a lower level, and the deficit it has built up, untouched. Priority changes take effect only between packets.

The block holds no packet data. Upstream logic reports each arriving packet through a valid/ready enqueue stream that carries the queue index and the packet length. The block keeps a short store of head lengths for each queue. It issues one grant per packet on a valid/ready grant stream, which the transmit side acknowledges when it takes the packet. Software writes the priority and quantum of a queue through a one-cycle register write. It may do so at any time.

The streams follow these back-pressure rules. The enqueue side may hold `enq_valid` while `enq_ready` is low. A beat offered while `enq_ready` is low is discarded and must be offered again. Once `gnt_valid` rises, it stays high with a fixed queue index and length until a cycle with `gnt_ready` high. That cycle consumes the grant.

Top module: `prio_drr_sched`

## Requirements
- R1: After reset `gnt_valid` is low. `enq_ready` is high for every queue. Every queue is at level 0 with quantum `QNT_RST`.
- R2: `enq_ready` is low exactly when the queue addressed by `enq_qid` already stores `DEPTH` packets. An enqueue beat offered while `enq_ready` is low is dropped and never produces a grant.
- R3: A grant stays valid, with a stable queue index and length, until `gnt_ready` is high. A queue's packets are granted in arrival order, and each grant carries the enqueued length. A consumed grant deasserts `gnt_valid` for at least one cycle.
- R4: Every grant goes to a queue at the numerically highest priority level among queues that hold packets. A larger value means a higher priority.
- R5: When a queue starts its turn, its deficit grows by its quantum. Its head packets are granted while their length is no greater than the deficit. Each grant subtracts that length.
- R6: A queue's turn ends when its head packet exceeds its deficit or the queue is empty. The turn then passes to the next backlogged queue of the same level in ascending circular index order. An unused deficit is carried into the next turn.
- R7: A queue emptied by a grant has its deficit cleared to zero.
- R8: Preemption happens only at packet boundaries. After a higher level drains, a lower level resumes with the same queue and the same remaining deficit it had.
- R9: A register write of priority or quantum applies from the next scheduling decision. It leaves a grant already on the port unchanged.
- R10: A granted length never exceeds the deficit the granted queue holds while the grant is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Packet arrival beat valid |
| enq_ready | output | 1 | Addressed queue can accept a packet |
| enq_qid | input | QID_W | Queue index of the arriving packet |
| enq_len | input | LEN_W | Length of the arriving packet |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | QID_W | Queue index being configured |
| cfg_prio | input | LVL_W | New priority level |
| cfg_quantum | input | QNT_W | New deficit round robin quantum |
| gnt_valid | output | 1 | Grant valid |
| gnt_ready | input | 1 | Transmit side accepts the grant |
| gnt_qid | output | QID_W | Granted queue index |
| gnt_len | output | LEN_W | Length of the granted packet |

## Verification
Faults in deficit bookkeeping show up as changes in grant order. If a deficit is not cleared when its queue empties, or is double-credited, that queue reappears earlier than it should within its own level. The error is visible by the second or third grant after the fault. A level pointer that a higher level disturbs shows up as the wrong queue on the first grant after the higher level drains. A broken head-length store shows up as a wrong `gnt_len`, or as an extra grant after a beat that should have been dropped. A corrupted in-flight grant shows up as a change on `gnt_qid` or `gnt_len` within one cycle of a configuration write.

// File: rtl/prio_drr_pkg.sv
package prio_drr_pkg;

  typedef enum logic {
    ST_PICK,
    ST_HOLD
  } sched_st_t;

  function automatic int unsigned wider(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prio_drr_lenq.sv
module prio_drr_lenq #(
  parameter int DEPTH = 4,
  parameter int LEN_W = 11,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LEN_W-1:0] push_len,
  input  logic             pop,
  output logic [LEN_W-1:0] head_len,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LEN_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_len;
        wr_ptr      <= step(wr_ptr);
      end
      if (pop) rd_ptr <= step(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head_len = mem[rd_ptr];

endmodule

// File: rtl/prio_drr_toplvl.sv
module prio_drr_toplvl #(
  parameter int NQ    = 64,
  parameter int LVL_W = 3
) (
  input  logic [NQ-1:0]            busy,
  input  logic [NQ-1:0][LVL_W-1:0] prio,
  output logic [LVL_W-1:0]         top,
  output logic                     any
);
  always_comb begin
    top = '0;
    any = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      if (busy[i]) begin
        any = 1'b1;
        if (prio[i] > top) top = prio[i];
      end
    end
  end
endmodule

// File: rtl/prio_drr_rrpick.sv
module prio_drr_rrpick #(
  parameter int NQ    = 64,
  parameter int QID_W = 6
) (
  input  logic [NQ-1:0]    mask,
  input  logic [QID_W-1:0] start,
  output logic [QID_W-1:0] nxt
);
  always_comb begin
    nxt = start;
    for (int k = NQ; k >= 1; k--) begin
      int unsigned idx;
      idx = (int'(start) + k) % NQ;
      if (mask[idx]) nxt = idx[QID_W-1:0];
    end
  end
endmodule

// File: rtl/prio_drr_sched.sv
module prio_drr_sched
  import prio_drr_pkg::*;
#(
  parameter int NQ      = 64,
  parameter int NLVL    = 8,
  parameter int LEN_W   = 11,
  parameter int QNT_W   = 12,
  parameter int DEPTH   = 4,
  parameter int QNT_RST = 1500,
  localparam int QID_W  = $clog2(NQ),
  localparam int LVL_W  = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [QID_W-1:0] enq_qid,
  input  logic [LEN_W-1:0] enq_len,
  input  logic             cfg_we,
  input  logic [QID_W-1:0] cfg_qid,
  input  logic [LVL_W-1:0] cfg_prio,
  input  logic [QNT_W-1:0] cfg_quantum,
  output logic             gnt_valid,
  input  logic             gnt_ready,
  output logic [QID_W-1:0] gnt_qid,
  output logic [LEN_W-1:0] gnt_len
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int DEF_W = wider(LEN_W, QNT_W) + 1;

  logic [NQ-1:0][LVL_W-1:0]   q_prio;
  logic [NQ-1:0][QNT_W-1:0]   q_qnt;
  logic [NQ-1:0][DEF_W-1:0]   q_def;
  logic [NQ-1:0][CNT_W-1:0]   q_cnt;
  logic [NQ-1:0][LEN_W-1:0]   q_head;
  logic [NQ-1:0]              q_seen, q_busy, q_push, q_pop, lvl_mask;
  logic [NLVL-1:0][QID_W-1:0] lvl_ptr;

  sched_st_t        st;
  logic [LVL_W-1:0] top_lvl;
  logic             any_busy, enq_fire, pop_fire, cur_ok, head_fits, drain_last;
  logic [QID_W-1:0] cur_q, rr_next;

  assign enq_ready = (q_cnt[enq_qid] != CNT_W'(DEPTH));
  assign enq_fire  = enq_valid && enq_ready;
  assign pop_fire  = gnt_valid && gnt_ready;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign q_push[g]   = enq_fire && (enq_qid == QID_W'(g));
    assign q_pop[g]    = pop_fire && (gnt_qid == QID_W'(g));
    assign q_busy[g]   = (q_cnt[g] != '0);
    assign lvl_mask[g] = q_busy[g] && (q_prio[g] == top_lvl);

    prio_drr_lenq #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_lenq (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (q_push[g]),
      .push_len (enq_len),
      .pop      (q_pop[g]),
      .head_len (q_head[g]),
      .count    (q_cnt[g])
    );
  end

  prio_drr_toplvl #(.NQ(NQ), .LVL_W(LVL_W)) u_toplvl (
    .busy (q_busy),
    .prio (q_prio),
    .top  (top_lvl),
    .any  (any_busy)
  );

  assign cur_q = lvl_ptr[top_lvl];

  prio_drr_rrpick #(.NQ(NQ), .QID_W(QID_W)) u_rrpick (
    .mask  (lvl_mask),
    .start (cur_q),
    .nxt   (rr_next)
  );

  assign cur_ok     = lvl_mask[cur_q];
  assign head_fits  = DEF_W'(q_head[cur_q]) <= q_def[cur_q];
  assign drain_last = (q_cnt[gnt_qid] == CNT_W'(1)) && !q_push[gnt_qid];

  // Configuration registers: sampled by the scheduler only when it decides
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) begin
        q_prio[i] <= '0;
        q_qnt[i]  <= QNT_W'(QNT_RST);
      end
    end else if (cfg_we) begin
      q_prio[cfg_qid] <= cfg_prio;
      q_qnt[cfg_qid]  <= cfg_quantum;
    end
  end

  // Decision and grant hold
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_PICK;
      gnt_valid <= 1'b0;
      gnt_qid   <= '0;
      gnt_len   <= '0;
      q_def     <= '0;
      q_seen    <= '0;
      lvl_ptr   <= '0;
    end else begin
      case (st)
        ST_PICK: begin
          if (any_busy) begin
            if (!cur_ok) begin
              lvl_ptr[top_lvl] <= rr_next;
            end else if (!q_seen[cur_q]) begin
              q_def[cur_q]  <= q_def[cur_q] + DEF_W'(q_qnt[cur_q]);
              q_seen[cur_q] <= 1'b1;
            end else if (head_fits) begin
              gnt_valid <= 1'b1;
              gnt_qid   <= cur_q;
              gnt_len   <= q_head[cur_q];
              st        <= ST_HOLD;
            end else begin
              q_seen[cur_q]    <= 1'b0;
              lvl_ptr[top_lvl] <= rr_next;
            end
          end
        end
        ST_HOLD: begin
          if (gnt_ready) begin
            gnt_valid <= 1'b0;
            st        <= ST_PICK;
            if (drain_last) begin
              q_def[gnt_qid]  <= '0;
              q_seen[gnt_qid] <= 1'b0;
            end else begin
              q_def[gnt_qid] <= q_def[gnt_qid] - DEF_W'(gnt_len);
            end
          end
        end
        default: st <= ST_PICK;
      endcase
    end
  end

endmodule

// File: rtl/prio_drr_chk.sv
module prio_drr_chk #(
  parameter int NQ    = 64,
  parameter int QID_W = 6,
  parameter int LEN_W = 11,
  parameter int CNT_W = 3,
  parameter int DEF_W = 13
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   enq_valid,
  input logic                   enq_ready,
  input logic [QID_W-1:0]       enq_qid,
  input logic                   gnt_valid,
  input logic                   gnt_ready,
  input logic [QID_W-1:0]       gnt_qid,
  input logic [LEN_W-1:0]       gnt_len,
  input logic [NQ-1:0][CNT_W-1:0] q_cnt,
  input logic [NQ-1:0][DEF_W-1:0] q_def
);
  // R3
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_qid) && $stable(gnt_len));

  // R3
  gnt_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && gnt_ready |=> !gnt_valid);

  // R3
  gnt_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> q_cnt[gnt_qid] != '0);

  // R10
  gnt_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> DEF_W'(gnt_len) <= q_def[gnt_qid]);

  // R7
  drain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && gnt_ready && q_cnt[gnt_qid] == CNT_W'(1)
      && !(enq_valid && enq_ready && enq_qid == gnt_qid)
    |=> q_def[$past(gnt_qid)] == '0);

  // R2
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid && !enq_ready && !(gnt_valid && gnt_ready && gnt_qid == enq_qid)
    |=> q_cnt[$past(enq_qid)] == $past(q_cnt[enq_qid]));

endmodule

bind prio_drr_sched prio_drr_chk #(
  .NQ(NQ), .QID_W(QID_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .DEF_W(DEF_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enq_valid (enq_valid),
  .enq_ready (enq_ready),
  .enq_qid   (enq_qid),
  .gnt_valid (gnt_valid),
  .gnt_ready (gnt_ready),
  .gnt_qid   (gnt_qid),
  .gnt_len   (gnt_len),
  .q_cnt     (q_cnt),
  .q_def     (q_def)
);

// File: tb/prio_drr_sched_tb.sv
module prio_drr_sched_tb;
  localparam int NQ    = 64;
  localparam int NLVL  = 8;
  localparam int LEN_W = 11;
  localparam int QNT_W = 12;
  localparam int QID_W = $clog2(NQ);
  localparam int LVL_W = $clog2(NLVL);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             enq_valid, enq_ready;
  logic [QID_W-1:0] enq_qid;
  logic [LEN_W-1:0] enq_len;
  logic             cfg_we;
  logic [QID_W-1:0] cfg_qid;
  logic [LVL_W-1:0] cfg_prio;
  logic [QNT_W-1:0] cfg_quantum;
  logic             gnt_valid, gnt_ready;
  logic [QID_W-1:0] gnt_qid;
  logic [LEN_W-1:0] gnt_len;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  prio_drr_sched #(.NQ(NQ), .NLVL(NLVL), .LEN_W(LEN_W), .QNT_W(QNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_qid(enq_qid), .enq_len(enq_len),
    .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_prio(cfg_prio), .cfg_quantum(cfg_quantum),
    .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_qid(gnt_qid), .gnt_len(gnt_len)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; enq_valid = 1'b0; enq_qid = '0; enq_len = '0;
    cfg_we = 1'b0; cfg_qid = '0; cfg_prio = '0; cfg_quantum = '0; gnt_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input int q, input int p, input int qnt);
    cfg_we = 1'b1; cfg_qid = QID_W'(q); cfg_prio = LVL_W'(p); cfg_quantum = QNT_W'(qnt);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic enq(input int q, input int len);
    enq_valid = 1'b1; enq_qid = QID_W'(q); enq_len = LEN_W'(len);
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic expect_grant(input int q, input int len, input string tag);
    int n = 0;
    while (!gnt_valid && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(gnt_valid && int'(gnt_qid) == q, {tag, " grant queue"}, gnt_valid ? int'(gnt_qid) : -1, q);
    check(int'(gnt_len) == len, {tag, " grant length"}, int'(gnt_len), len);
    gnt_ready = 1'b1;
    @(negedge clk);
    gnt_ready = 1'b0;
  endtask

  task automatic expect_idle(input int cycles, input string tag);
    bit seen = 1'b0;
    repeat (cycles) begin
      @(negedge clk);
      if (gnt_valid) seen = 1'b1;
    end
    check(!seen, tag, int'(seen), 0);
  endtask

  // R1
  task automatic t_reset();
    do_reset();
    check(gnt_valid == 1'b0, "R1 grant low after reset", int'(gnt_valid), 0);
    enq_qid = QID_W'(9);
    #1;
    check(enq_ready == 1'b1, "R1 enqueue ready after reset", int'(enq_ready), 1);
    expect_idle(10, "R1 no grant without packets");
  endtask

  // R5 R6 R3: equal quanta, one level
  task automatic t_drr_basic();
    do_reset();
    enq(1, 100); enq(1, 110); enq(2, 120); enq(2, 130); enq(3, 140); enq(3, 150);
    expect_grant(1, 100, "R5 first");
    expect_grant(1, 110, "R5 same turn");
    expect_grant(2, 120, "R6 next queue");
    expect_grant(2, 130, "R3 arrival order");
    expect_grant(3, 140, "R6 third queue");
    expect_grant(3, 150, "R5 third queue drain");
  endtask

  // R5 R6: small quanta carry deficit across turns
  task automatic t_drr_quantum();
    do_reset();
    cfg(5, 0, 300);
    cfg(6, 0, 300);
    enq(5, 200); enq(5, 200); enq(5, 200); enq(6, 200); enq(6, 200);
    expect_grant(5, 200, "R5 q5 turn1");
    expect_grant(6, 200, "R6 q6 turn1");
    expect_grant(5, 200, "R6 q5 turn2 carried deficit");
    expect_grant(5, 200, "R5 q5 turn2 second");
    expect_grant(6, 200, "R6 q6 turn2");
  endtask

  // R4: strict priority across levels
  task automatic t_strict();
    do_reset();
    cfg(10, 2, 1500); cfg(11, 5, 1500); cfg(12, 2, 1500); cfg(13, 1, 1500);
    enq(11, 60); enq(11, 61); enq(10, 62); enq(12, 63); enq(13, 64);
    expect_grant(11, 60, "R4 top level");
    expect_grant(11, 61, "R4 top level drain");
    expect_grant(10, 62, "R4 middle level");
    expect_grant(12, 63, "R4 middle level rotation");
    expect_grant(13, 64, "R4 lowest level last");
  endtask

  // R8: preemption at packet boundary keeps lower level state
  task automatic t_preempt();
    do_reset();
    cfg(21, 7, 1500);
    enq(20, 100); enq(20, 101); enq(20, 102);
    expect_grant(20, 100, "R8 low first");
    while (!gnt_valid) @(negedge clk);
    enq(21, 200);
    check(gnt_valid && int'(gnt_qid) == 20 && int'(gnt_len) == 101,
          "R8 held grant not interrupted", int'(gnt_qid), 20);
    expect_grant(20, 101, "R8 held grant");
    expect_grant(21, 200, "R8 high preempts");
    expect_grant(20, 102, "R8 low resumes");
  endtask

  // R9: configuration during a held grant
  task automatic t_cfg_live();
    do_reset();
    enq(30, 300); enq(30, 301); enq(31, 310); enq(31, 311);
    while (!gnt_valid) @(negedge clk);
    cfg(31, 6, 1500);
    cfg(30, 3, 100);
    check(gnt_valid && int'(gnt_qid) == 30, "R9 held queue stable", int'(gnt_qid), 30);
    check(int'(gnt_len) == 300, "R9 held length stable", int'(gnt_len), 300);
    expect_grant(30, 300, "R9 held grant");
    expect_grant(31, 310, "R9 new priority applied");
    expect_grant(31, 311, "R9 new priority drain");
    expect_grant(30, 301, "R9 lowered queue last");
  endtask

  // R2: back-pressure on a full queue, dropped beat
  task automatic t_backpressure();
    do_reset();
    enq(40, 100); enq(40, 101); enq(40, 102); enq(40, 103);
    enq_qid = QID_W'(40);
    #1;
    check(enq_ready == 1'b0, "R2 full queue not ready", int'(enq_ready), 0);
    enq_qid = QID_W'(41);
    #1;
    check(enq_ready == 1'b1, "R2 other queue ready", int'(enq_ready), 1);
    enq(40, 999);
    expect_grant(40, 100, "R2 drain 1");
    expect_grant(40, 101, "R2 drain 2");
    expect_grant(40, 102, "R2 drain 3");
    expect_grant(40, 103, "R2 drain 4");
    expect_idle(40, "R2 dropped beat never granted");
  endtask

  // R7: emptied queue forgets leftover deficit
  task automatic t_deficit_clear();
    do_reset();
    cfg(50, 0, 1000);
    enq(50, 100);
    expect_grant(50, 100, "R7 leave leftover");
    enq(52, 100); enq(50, 1200); enq(51, 100);
    expect_grant(52, 100, "R7 rotation start");
    expect_grant(51, 100, "R7 cleared deficit passes turn");
    expect_grant(50, 1200, "R7 second turn grant");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R3 actual=hung expected=complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_drr_basic();
    t_drr_quantum();
    t_strict();
    t_preempt();
    t_cfg_live();
    t_backpressure();
    t_deficit_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule